// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit sits between the decode stage and the data memory port of a small 32-bit core. For each memory operation it takes a base value, an offset value and a short immediate. It forms the effective address in one of four addressing modes, scaling the immediate by the access width where the mode calls for it. It then checks that the address is naturally aligned for the chosen width.

An aligned operation becomes one request on a memory port that uses a valid/ready handshake. The request carries per-byte lane enables and the store data copied onto those lanes. For a load, the unit captures the one-cycle response. It moves the addressed byte or halfword to the bottom of the result and widens it to 32 bits, with zero or sign fill.

A misaligned operation never reaches memory. Instead the unit raises a one-cycle fault pulse and reports the offending address. The unit takes one operation at a time and accepts a new one only while it is idle.

Top module: `lsu_agu`

## Requirements
- R1: In register-offset mode (op_mode 0) the address is base_val + ofs_val, modulo 2^32, with no scaling of the offset.
- R2: In immediate-offset mode (op_mode 1) the address is base_val plus imm_val[4:0], zero-extended. The immediate is shifted left by 2 for word, by 1 for halfword and not at all for byte. imm_val[7:5] is ignored. The op_size codes are 0 for byte, 1 for halfword, and 2 or 3 for word.
- R3: In stack-relative mode (op_mode 2) the address is base_val + (zero-extended imm_val[7:0] << 2).
- R4: In PC-relative mode (op_mode 3) the address is ((base_val + 4) with bits [1:0] cleared) + (imm_val[7:0] << 2).
- R5: A halfword at an odd address, or a word whose address bits [1:0] are not 00, raises fault_pulse for exactly the cycle after acceptance, with fault_addr set to the effective address. It issues no memory request, and the unit stays ready.
- R6: mem_lanes is 4'b0001 << addr[1:0] for a byte, 4'b0011 for a halfword at addr[1]=0, 4'b1100 for a halfword at addr[1]=1, and 4'b1111 for a word.
- R7: For a store, mem_wdata holds st_data[7:0] in all four bytes for a byte access, st_data[15:0] in both halves for a halfword access, and st_data unchanged for a word access. mem_write is 1 for a store and 0 for a load.
- R8: mem_req_valid rises the cycle after an aligned operation is accepted. Address, lanes, write data and direction hold stable until a cycle with mem_req_ready high.
- R9: A load returns the addressed byte (mem_rsp_data shifted right by 8*addr[1:0]) or halfword (shifted right by 16*addr[1]), sign-extended when op_signed is 1 and zero-extended when it is 0. A word load returns mem_rsp_data unchanged whatever op_signed is.
- R10: ld_valid pulses for one cycle, the cycle after mem_rsp_valid is seen while a load waits. op_ready is low from acceptance until the operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation accepted when op_valid is high |
| op_store | input | 1 | 1 store, 0 load |
| op_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| op_signed | input | 1 | Sign-extend a load result |
| op_mode | input | 2 | 0 register offset, 1 immediate offset, 2 stack-relative, 3 PC-relative |
| base_val | input | 32 | Base register, stack pointer or PC value |
| ofs_val | input | 32 | Offset register value |
| imm_val | input | 8 | Immediate field |
| st_data | input | 32 | Store data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_addr | output | 32 | Request address |
| mem_write | output | 1 | Request is a write |
| mem_lanes | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rsp_valid | input | 1 | One-cycle read response strobe |
| mem_rsp_data | input | 32 | Read response data |
| ld_valid | output | 1 | Load result valid pulse |
| ld_data | output | 32 | Extended load result |
| fault_pulse | output | 1 | Misalignment fault pulse |
| fault_addr | output | 32 | Address of the faulting operation |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, a 32-bit data path and a PC look-ahead of 4. The full-width address lets a base near the top of memory wrap through zero, and the bench checks that wrap. The 4-lane data path gives every byte and halfword position a lane pattern of its own to compare. With these values the bench reaches every mode and width, both sign fills, a stalled request, and faults issued back to back with legal operations.

// File: rtl/lsu_agu_pkg.sv
package lsu_agu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        AM_REG = 2'd0,
        AM_IMM = 2'd1,
        AM_SP  = 2'd2,
        AM_PC  = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } lsu_state_e;

endpackage

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
    import lsu_agu_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IMM_W    = 8,
    parameter int SHORT_W  = 5,
    parameter int PC_AHEAD = 4
) (
    input  addr_mode_e        mode,
    input  acc_size_e         size,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] ofs,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] ea
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

    logic [ADDR_W-1:0] short_z;
    logic [ADDR_W-1:0] long_z;
    logic [ADDR_W-1:0] short_scaled;
    logic [ADDR_W-1:0] pc_base;

    always_comb begin
        short_z = ADDR_W'(imm[SHORT_W-1:0]);
        long_z  = ADDR_W'(imm);
        case (size)
            SZ_BYTE: short_scaled = short_z;
            SZ_HALF: short_scaled = short_z << 1;
            default: short_scaled = short_z << 2;
        endcase
        pc_base = (base + ADDR_W'(PC_AHEAD)) & WORD_MASK;
        case (mode)
            AM_REG:  ea = base + ofs;
            AM_IMM:  ea = base + short_scaled;
            AM_SP:   ea = base + (long_z << 2);
            default: ea = pc_base + (long_z << 2);
        endcase
    end
endmodule

// File: rtl/agu_lane_align.sv
module agu_lane_align
    import lsu_agu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LB    = $clog2(LANES)
) (
    input  acc_size_e         size,
    input  logic [LB-1:0]     addr_lo,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [LANES-1:0]  lanes,
    output logic              misaligned,
    output logic [DATA_W-1:0] wdata_out
);
    logic [LB-1:0] half_base;
    logic [LB-1:0] word_base;

    always_comb begin
        half_base = {addr_lo[LB-1:1], 1'b0};
        word_base = {addr_lo[LB-1:2], 2'b00};
        case (size)
            SZ_BYTE: begin
                lanes      = LANES'(1) << addr_lo;
                misaligned = 1'b0;
            end
            SZ_HALF: begin
                lanes      = LANES'(2'b11) << half_base;
                misaligned = addr_lo[0];
            end
            default: begin
                lanes      = LANES'(4'hF) << word_base;
                misaligned = |addr_lo[1:0];
            end
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            case (size)
                SZ_BYTE: wdata_out[i*8 +: 8] = wdata_in[7:0];
                SZ_HALF: wdata_out[i*8 +: 8] = wdata_in[(i % 2)*8 +: 8];
                default: wdata_out[i*8 +: 8] = wdata_in[(i % 4)*8 +: 8];
            endcase
        end
    end
endmodule

// File: rtl/agu_load_ext.sv
module agu_load_ext
    import lsu_agu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int LB    = $clog2(LANES)
) (
    input  acc_size_e         size,
    input  logic              sgn,
    input  logic [LB-1:0]     addr_lo,
    input  logic [DATA_W-1:0] rdata,
    output logic [31:0]       value
);
    logic [DATA_W-1:0] shifted;
    logic [7:0]        b;
    logic [15:0]       h;

    always_comb begin
        shifted = rdata >> {addr_lo, 3'b000};
        b = shifted[7:0];
        h = shifted[15:0];
        case (size)
            SZ_BYTE: value = {{24{sgn & b[7]}}, b};
            SZ_HALF: value = {{16{sgn & h[15]}}, h};
            default: value = shifted[31:0];
        endcase
    end
endmodule

// File: rtl/lsu_agu.sv
module lsu_agu
    import lsu_agu_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int IMM_W    = 8,
    parameter int PC_AHEAD = 4,
    localparam int LANES   = DATA_W / 8,
    localparam int LB      = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic              op_store,
    input  logic [1:0]        op_size,
    input  logic              op_signed,
    input  logic [1:0]        op_mode,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] ofs_val,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic [DATA_W-1:0] st_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_write,
    output logic [LANES-1:0]  mem_lanes,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              ld_valid,
    output logic [31:0]       ld_data,
    output logic              fault_pulse,
    output logic [ADDR_W-1:0] fault_addr
);
    typedef struct packed {
        lsu_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lanes;
        logic [DATA_W-1:0] wdata;
        logic              wr;
        acc_size_e         sz;
        logic              sgn;
        logic              ld_v;
        logic [31:0]       ld_d;
        logic              flt;
        logic [ADDR_W-1:0] flt_a;
    } regs_t;

    regs_t r_d, r_q;

    acc_size_e         size_in;
    addr_mode_e        mode_in;
    logic [ADDR_W-1:0] ea;
    logic [LANES-1:0]  lanes_c;
    logic              mis_c;
    logic [DATA_W-1:0] wdata_c;
    logic [31:0]       ext_c;

    assign size_in = acc_size_e'(op_size);
    assign mode_in = addr_mode_e'(op_mode);

    agu_addr_calc #(
        .ADDR_W  (ADDR_W),
        .IMM_W   (IMM_W),
        .SHORT_W (5),
        .PC_AHEAD(PC_AHEAD)
    ) u_calc (
        .mode(mode_in),
        .size(size_in),
        .base(base_val),
        .ofs (ofs_val),
        .imm (imm_val),
        .ea  (ea)
    );

    agu_lane_align #(.DATA_W(DATA_W)) u_align (
        .size      (size_in),
        .addr_lo   (ea[LB-1:0]),
        .wdata_in  (st_data),
        .lanes     (lanes_c),
        .misaligned(mis_c),
        .wdata_out (wdata_c)
    );

    agu_load_ext #(.DATA_W(DATA_W)) u_ext (
        .size   (r_q.sz),
        .sgn    (r_q.sgn),
        .addr_lo(r_q.addr[LB-1:0]),
        .rdata  (mem_rsp_data),
        .value  (ext_c)
    );

    always_comb begin
        r_d      = r_q;
        r_d.ld_v = 1'b0;
        r_d.flt  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (op_valid) begin
                    if (mis_c) begin
                        r_d.flt   = 1'b1;
                        r_d.flt_a = ea;
                    end else begin
                        r_d.st    = ST_REQ;
                        r_d.addr  = ea;
                        r_d.lanes = lanes_c;
                        r_d.wdata = wdata_c;
                        r_d.wr    = op_store;
                        r_d.sz    = size_in;
                        r_d.sgn   = op_signed;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    r_d.st = r_q.wr ? ST_IDLE : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.st   = ST_IDLE;
                    r_d.ld_v = 1'b1;
                    r_d.ld_d = ext_c;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign op_ready      = (r_q.st == ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_REQ);
    assign mem_addr      = r_q.addr;
    assign mem_write     = r_q.wr;
    assign mem_lanes     = r_q.lanes;
    assign mem_wdata     = r_q.wdata;
    assign ld_valid      = r_q.ld_v;
    assign ld_data       = r_q.ld_d;
    assign fault_pulse   = r_q.flt;
    assign fault_addr    = r_q.flt_a;

    // R8: request fields frozen while memory stalls
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)
        && $stable(mem_lanes) && $stable(mem_wdata) && $stable(mem_write));

    // R5: a fault never coincides with a memory request
    p_fault_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> !mem_req_valid && op_ready);

    // R5: any full-word request leaves memory word aligned
    p_word_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && (&mem_lanes) |-> mem_addr[1:0] == 2'b00);

    // R6: lane pattern has 1, 2 or 4 lanes set
    p_lane_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ($countones(mem_lanes) == 1 || $countones(mem_lanes) == 2
                           || $countones(mem_lanes) == 4));

    // R10: load result only after a response strobe
    p_ld_after_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_rsp_valid));

    // R10: unit is busy while a request is outstanding
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !op_ready);

endmodule

// File: tb/sim_lsu_agu.sv
`timescale 1ns/1ps
module sim_lsu_agu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_ready, op_store = 1'b0, op_signed = 1'b0;
    logic [1:0]  op_size = 2'd0, op_mode = 2'd0;
    logic [31:0] base_val = '0, ofs_val = '0, st_data = '0;
    logic [7:0]  imm_val = '0;
    logic        mem_req_valid, mem_req_ready = 1'b0, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_lanes;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        ld_valid, fault_pulse;
    logic [31:0] ld_data, fault_addr;

    always #5 clk = ~clk;

    lsu_agu u0 (.*);

    typedef struct {
        int          kind;   // 0 fault, 1 store, 2 load
        logic [31:0] addr;
        logic [3:0]  lanes;
        logic [31:0] wdata;
        logic [31:0] rdata;
        logic [31:0] ld;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0, errors = 0;
    int stall_cfg = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ea(input logic [1:0] mode, input logic [1:0] sz,
        input logic [31:0] b, input logic [31:0] o, input logic [7:0] im);
        logic [31:0] s;
        s = {27'd0, im[4:0]};
        case (mode)
            2'd0: return b + o;
            2'd1: return b + (sz == 2'd0 ? s : (sz == 2'd1 ? s * 2 : s * 4));
            2'd2: return b + {22'd0, im, 2'b00};
            default: return ((b + 32'd4) & 32'hFFFF_FFFC) + {22'd0, im, 2'b00};
        endcase
    endfunction

    task automatic do_op(input bit st, input logic [1:0] sz, input bit sg,
        input logic [1:0] mode, input logic [31:0] b, input logic [31:0] o,
        input logic [7:0] im, input logic [31:0] wd, input logic [31:0] rd,
        input string tag);
        item_t it;
        logic [31:0] a;
        logic [31:0] sh;
        bit mis;
        a = exp_ea(mode, sz, b, o, im);
        mis = (sz == 2'd1) ? a[0] : (sz >= 2'd2) ? (a[1:0] != 2'b00) : 1'b0;
        it.addr = a; it.rdata = rd; it.tag = tag;
        it.kind = mis ? 0 : (st ? 1 : 2);
        case (sz)
            2'd0: begin it.lanes = 4'b0001 << a[1:0]; it.wdata = {4{wd[7:0]}}; end
            2'd1: begin it.lanes = a[1] ? 4'b1100 : 4'b0011; it.wdata = {2{wd[15:0]}}; end
            default: begin it.lanes = 4'b1111; it.wdata = wd; end
        endcase
        sh = rd >> (8 * a[1:0]);
        case (sz)
            2'd0: it.ld = sg ? {{24{sh[7]}}, sh[7:0]} : {24'd0, sh[7:0]};
            2'd1: it.ld = sg ? {{16{sh[15]}}, sh[15:0]} : {16'd0, sh[15:0]};
            default: it.ld = rd;
        endcase
        @(negedge clk);
        while (!op_ready) @(negedge clk);
        op_valid = 1'b1; op_store = st; op_size = sz; op_signed = sg; op_mode = mode;
        base_val = b; ofs_val = o; imm_val = im; st_data = wd;
        q.push_back(it);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // memory model and monitor
    initial begin
        bit in_req = 0, held = 0, pend = 0;
        int stall_left = 0;
        logic [31:0] s_addr, s_wdata;
        logic [3:0]  s_lanes;
        logic        s_wr;
        item_t f;
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (fault_pulse) begin
                if (q.size() == 0) chk(0, "R5", "unexpected fault", fault_addr, 0);
                else begin
                    f = q.pop_front();
                    chk(f.kind == 0, f.tag, "fault on legal op", 1, 0);
                    chk(fault_addr == f.addr, f.tag, "fault_addr", fault_addr, f.addr);
                    chk(op_ready == 1'b1, "R5", "ready after fault", op_ready, 1);
                end
            end
            if (ld_valid) begin
                if (q.size() == 0) chk(0, "R10", "unexpected ld_valid", ld_data, 0);
                else begin
                    f = q.pop_front();
                    chk(f.kind == 2, f.tag, "ld_valid kind", f.kind, 2);
                    chk(ld_data == f.ld, f.tag, "ld_data", ld_data, f.ld);
                end
            end
            if (mem_rsp_valid) mem_rsp_valid = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1; mem_rsp_data = q[0].rdata; pend = 0;
            end
            if (mem_req_valid) begin
                if (!in_req) begin in_req = 1; stall_left = stall_cfg; stall_cfg = 0; end
                else if (held) begin
                    chk(mem_addr == s_addr, "R8", "addr held", mem_addr, s_addr);
                    chk(mem_lanes == s_lanes && mem_wdata == s_wdata && mem_write == s_wr,
                        "R8", "fields held", mem_wdata, s_wdata);
                end
                if (stall_left > 0) begin
                    stall_left--; mem_req_ready = 1'b0; held = 1;
                    s_addr = mem_addr; s_lanes = mem_lanes; s_wdata = mem_wdata; s_wr = mem_write;
                end else begin
                    mem_req_ready = 1'b1; held = 0; in_req = 0;
                    chk(op_ready == 1'b0, "R10", "busy during request", op_ready, 0);
                    if (q.size() == 0) chk(0, "R5", "unexpected request", mem_addr, 0);
                    else begin
                        f = q[0];
                        chk(f.kind != 0, f.tag, "request on misaligned op", mem_addr, f.addr);
                        chk(mem_addr == f.addr, f.tag, "mem_addr", mem_addr, f.addr);
                        chk(mem_lanes == f.lanes, {f.tag, "/R6"}, "mem_lanes", {28'd0, mem_lanes}, {28'd0, f.lanes});
                        chk(mem_write == (f.kind == 1), {f.tag, "/R7"}, "mem_write", mem_write, f.kind == 1);
                        if (f.kind == 1) begin
                            chk(mem_wdata == f.wdata, {f.tag, "/R7"}, "mem_wdata", mem_wdata, f.wdata);
                            void'(q.pop_front());
                        end else pend = 1;
                    end
                end
            end else mem_req_ready = 1'b0;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(op_ready && !mem_req_valid && !ld_valid && !fault_pulse, "R10", "reset state",
            {28'd0, op_ready, mem_req_valid, ld_valid, fault_pulse}, 32'h8);
        rst_n = 1'b1;
        // R1 word load, signed flag ignored for word (R9)
        do_op(0, 2'd2, 1, 2'd0, 32'h0000_1000, 32'h24, 8'h00, 0, 32'h89AB_CDEF, "R1");
        // R1 wrap through zero, word store
        do_op(1, 2'd2, 0, 2'd0, 32'hFFFF_FFFC, 32'h8, 8'h00, 32'hCAFE_F00D, 0, "R1");
        // R2 word immediate with upper bits set (ignored)
        do_op(1, 2'd2, 0, 2'd1, 32'h0000_2000, 0, 8'hE3, 32'h1111_2222, 0, "R2");
        // R2 halfword immediate, unsigned load at upper half
        do_op(0, 2'd1, 0, 2'd1, 32'h0000_2000, 0, 8'h05, 0, 32'hF00D_1234, "R2");
        // R2 byte immediate, signed load from lane 3
        do_op(0, 2'd0, 1, 2'd1, 32'h0000_2000, 0, 8'h07, 0, 32'h8012_3456, "R2");
        // R3 stack-relative max immediate
        do_op(0, 2'd2, 0, 2'd2, 32'h0000_3000, 0, 8'hFF, 0, 32'h0BAD_BEEF, "R3");
        // R4 PC-relative from a halfword-aligned PC
        do_op(0, 2'd2, 0, 2'd3, 32'h0000_4002, 0, 8'h01, 0, 32'h1234_5678, "R4");
        do_op(0, 2'd2, 0, 2'd3, 32'h0000_4000, 0, 8'h00, 0, 32'h5555_AAAA, "R4");
        // R5 misaligned halfword and word, back to back with a legal byte
        do_op(0, 2'd1, 0, 2'd0, 32'h0000_5001, 0, 8'h00, 0, 0, "R5");
        do_op(1, 2'd2, 0, 2'd0, 32'h0000_5002, 0, 8'h00, 32'hDEAD_BEEF, 0, "R5");
        do_op(0, 2'd0, 0, 2'd0, 32'h0000_5001, 0, 8'h00, 0, 32'h0000_7F00, "R5");
        // R7 store replication and R6 lanes
        do_op(1, 2'd0, 0, 2'd0, 32'h0000_6001, 0, 8'h00, 32'h1234_56AB, 0, "R7");
        do_op(1, 2'd1, 0, 2'd0, 32'h0000_6002, 0, 8'h00, 32'h1234_BEEF, 0, "R7");
        // R9 signed halfword low, unsigned byte lane 2
        do_op(0, 2'd1, 1, 2'd0, 32'h0000_7000, 0, 8'h00, 0, 32'h0000_8001, "R9");
        do_op(0, 2'd0, 0, 2'd0, 32'h0000_7002, 0, 8'h00, 0, 32'h00FE_0000, "R9");
        // R8 stalled store and stalled load
        @(negedge clk); while (!op_ready) @(negedge clk);
        stall_cfg = 3;
        do_op(1, 2'd1, 0, 2'd1, 32'h0000_8000, 0, 8'h03, 32'h0000_A5A5, 0, "R8");
        @(negedge clk); while (!op_ready || q.size() != 0) @(negedge clk);
        stall_cfg = 2;
        do_op(0, 2'd0, 1, 2'd2, 32'h0000_9000, 0, 8'h02, 0, 32'h0000_00C0, "R8");
        repeat (20) @(negedge clk);
        chk(q.size() == 0, "R10", "all operations completed", q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule